// File: doc/BRIEF.md
# Polled Keyboard and Printer Port Pair

This block gives a simple processor two character devices behind its IN/OUT port space. Both devices sit on one I/O address bus that serves input and output operations alike. A keyboard latches key codes. A printer accepts bytes. Each device shows a one-bit status through a port of its own, and software waits on that status by polling it in a loop.

The ports have side effects. An IN from the keyboard data port empties the keyboard status. An OUT to the printer data port marks the printer busy. The printer marks itself ready again by pulsing its ready strobe. The device side uses only strobes, so the block needs no handshake.

Each device is a two-state machine. The keyboard states are `KB_EMPTY` and `KB_HELD`:
- transition *key arrives*: any state goes to `KB_HELD` on a key strobe.
- transition *key consumed*: `KB_HELD` goes to `KB_EMPTY` on an IN from the keyboard data port with no strobe in that cycle.

The printer states are `PR_READY` and `PR_BUSY`:
- transition *byte sent*: `PR_READY` or `PR_BUSY` goes to `PR_BUSY` on an OUT to the printer data port with no ready strobe in that cycle.
- transition *printer ready*: any state goes to `PR_READY` on the ready strobe.

Top module: `kp_io_ports`

## Requirements
- R1: After reset, the keyboard status reads 16'h0000, the printer status reads 16'h0001, `prn_data` is 0 and `prn_pulse` is 0.
- R2: Port addresses are 0 for keyboard status, 1 for keyboard data, 2 for printer status and 3 for printer data. The address bus is shared by IN (`io_rd`) and OUT (`io_wr`).
- R3: A `key_strobe` high at a clock edge latches `key_code` into the keyboard data register and sets the keyboard status from the next cycle on.
- R4: While `io_rd` is high, `io_rdata` shows the addressed port in the same cycle. A status port reads 16'h0001 when set and 16'h0000 when clear. Keyboard data reads as the 8-bit code zero-extended to 16 bits.
- R5: An IN from port 1 clears the keyboard status at that clock edge. An IN from port 0 leaves the keyboard status unchanged.
- R6: When a key strobe and an IN from port 1 fall in the same cycle, the status stays set and the data register takes the new code. The IN still returns the old code.
- R7: An OUT to port 3 puts `io_wdata[7:0]` on `prn_data` from the next cycle on. It raises `prn_pulse` for exactly that one cycle and clears the printer status.
- R8: `prn_ready` sets the printer status from the next cycle on. When it coincides with an OUT to port 3, the status ends set.
- R9: An OUT to ports 0, 1 or 2, or to any unmapped address, changes no state and gives no print pulse. An IN from an unmapped address returns 16'h0000.
- R10: With `io_rd` low, `io_rdata` is 16'h0000, and no keyboard status is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| io_addr | input | 8 | Shared I/O port address |
| io_rd | input | 1 | IN operation in this cycle |
| io_wr | input | 1 | OUT operation in this cycle |
| io_wdata | input | 16 | OUT data |
| io_rdata | output | 16 | IN data, combinational |
| key_strobe | input | 1 | Keyboard has a new code |
| key_code | input | 8 | Key code from keyboard |
| prn_ready | input | 1 | Printer can take another byte |
| prn_data | output | 8 | Byte held for the printer |
| prn_pulse | output | 1 | One-cycle print command |

## Verification
The bench drives a key strobe in the same cycle as a keyboard data read. A design that let the clear win would lose a keystroke that the processor never saw. It also sends an OUT to printer data together with a ready strobe. A design that gave priority the other way would leave the printer marked busy forever.

Reads of the status ports are repeated to catch a decoder that clears the keyboard on the wrong port. OUTs to the wrong ports and to unmapped addresses are checked against a printer that would pulse or change its byte. A long random stretch with back-to-back printer writes checks that each write gives its own pulse.

// File: rtl/kp_io_pkg.sv
package kp_io_pkg;

    typedef enum logic [1:0] {
        PORT_KSTAT = 2'd0,
        PORT_KDATA = 2'd1,
        PORT_PSTAT = 2'd2,
        PORT_PDATA = 2'd3
    } port_sel_e;

    localparam int NUM_PORTS = 4;

    typedef enum logic {
        KB_EMPTY = 1'b0,
        KB_HELD  = 1'b1
    } kb_state_e;

    typedef enum logic {
        PR_BUSY  = 1'b0,
        PR_READY = 1'b1
    } pr_state_e;

    typedef struct packed {
        logic kstat_rd;
        logic kdata_rd;
        logic pstat_rd;
        logic pdata_wr;
    } port_strobe_t;

endpackage

// File: rtl/kp_io_decode.sv
module kp_io_decode
    import kp_io_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output port_strobe_t      strb
);

    logic [NUM_PORTS-1:0] match;

    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_match
        assign match[i] = (addr == ADDR_W'(i));
    end

    always_comb begin
        strb.kstat_rd = rd && match[PORT_KSTAT];
        strb.kdata_rd = rd && match[PORT_KDATA];
        strb.pstat_rd = rd && match[PORT_PSTAT];
        strb.pdata_wr = wr && match[PORT_PDATA];
    end

endmodule

// File: rtl/kp_kbd_port.sv
module kp_kbd_port
    import kp_io_pkg::*;
#(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_strobe,
    input  logic [CODE_W-1:0] key_code,
    input  logic              data_rd,
    output logic              full,
    output logic [CODE_W-1:0] code
);

    kb_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= KB_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            KB_EMPTY: if (key_strobe) state_d = KB_HELD;
            KB_HELD:  if (!key_strobe && data_rd) state_d = KB_EMPTY;
            default:  state_d = KB_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          code <= '0;
        else if (key_strobe) code <= key_code;
    end

    always_comb full = (state_q == KB_HELD);

endmodule

// File: rtl/kp_prn_port.sv
module kp_prn_port
    import kp_io_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ready_strobe,
    input  logic              data_wr,
    input  logic [BYTE_W-1:0] wbyte,
    output logic              idle,
    output logic [BYTE_W-1:0] out_byte,
    output logic              out_pulse
);

    pr_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PR_READY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PR_READY: if (data_wr && !ready_strobe) state_d = PR_BUSY;
            PR_BUSY:  if (ready_strobe) state_d = PR_READY;
            default:  state_d = PR_READY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_byte  <= '0;
            out_pulse <= 1'b0;
        end else begin
            out_pulse <= data_wr;
            if (data_wr) out_byte <= wbyte;
        end
    end

    always_comb idle = (state_q == PR_READY);

endmodule

// File: rtl/kp_io_ports.sv
module kp_io_ports
    import kp_io_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [DATA_W-1:0] io_wdata,
    output logic [DATA_W-1:0] io_rdata,
    input  logic              key_strobe,
    input  logic [CODE_W-1:0] key_code,
    input  logic              prn_ready,
    output logic [CODE_W-1:0] prn_data,
    output logic              prn_pulse
);

    localparam int PAD_W  = DATA_W - CODE_W;
    localparam int FLAG_W = DATA_W - 1;

    port_strobe_t      strb;
    logic              kbd_full;
    logic [CODE_W-1:0] kbd_code;
    logic              prn_idle;

    kp_io_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (io_addr),
        .rd   (io_rd),
        .wr   (io_wr),
        .strb (strb)
    );

    kp_kbd_port #(.CODE_W(CODE_W)) u_kbd (
        .clk        (clk),
        .rst_n      (rst_n),
        .key_strobe (key_strobe),
        .key_code   (key_code),
        .data_rd    (strb.kdata_rd),
        .full       (kbd_full),
        .code       (kbd_code)
    );

    kp_prn_port #(.BYTE_W(CODE_W)) u_prn (
        .clk          (clk),
        .rst_n        (rst_n),
        .ready_strobe (prn_ready),
        .data_wr      (strb.pdata_wr),
        .wbyte        (io_wdata[CODE_W-1:0]),
        .idle         (prn_idle),
        .out_byte     (prn_data),
        .out_pulse    (prn_pulse)
    );

    always_comb begin
        io_rdata = '0;
        if (strb.kstat_rd) io_rdata = {{FLAG_W{1'b0}}, kbd_full};
        if (strb.kdata_rd) io_rdata = {{PAD_W{1'b0}}, kbd_code};
        if (strb.pstat_rd) io_rdata = {{FLAG_W{1'b0}}, prn_idle};
    end

endmodule

// File: rtl/kp_io_checker.sv
module kp_io_checker #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int CODE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] io_addr,
    input logic              io_rd,
    input logic              io_wr,
    input logic [DATA_W-1:0] io_wdata,
    input logic [DATA_W-1:0] io_rdata,
    input logic              key_strobe,
    input logic [CODE_W-1:0] key_code,
    input logic              prn_ready,
    input logic [CODE_W-1:0] prn_data,
    input logic              prn_pulse,
    input logic              kbd_full,
    input logic              prn_idle
);

    logic kdata_in, kstat_in, pdata_out;
    assign kdata_in  = io_rd && (io_addr == ADDR_W'(1));
    assign kstat_in  = io_rd && (io_addr == ADDR_W'(0));
    assign pdata_out = io_wr && (io_addr == ADDR_W'(3));

    a_r3_strobe_sets: assert property (@(posedge clk) disable iff (!rst_n)
        key_strobe |=> kbd_full && (io_rd && io_addr == ADDR_W'(1)
                                    ? io_rdata[CODE_W-1:0] == $past(key_code) : 1'b1));

    a_r5_data_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (kdata_in && !key_strobe) |=> !kbd_full);

    a_r5_status_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (kstat_in && kbd_full && !key_strobe) |=> kbd_full);

    a_r7_write_pulses: assert property (@(posedge clk) disable iff (!rst_n)
        pdata_out |=> prn_pulse && prn_data == $past(io_wdata[CODE_W-1:0]));

    a_r9_no_stray_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !pdata_out |=> !prn_pulse && $stable(prn_data));

    a_r8_ready_wins: assert property (@(posedge clk) disable iff (!rst_n)
        prn_ready |=> prn_idle);

    a_r10_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !io_rd |-> io_rdata == '0);

endmodule

bind kp_io_ports kp_io_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CODE_W(CODE_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .io_addr    (io_addr),
    .io_rd      (io_rd),
    .io_wr      (io_wr),
    .io_wdata   (io_wdata),
    .io_rdata   (io_rdata),
    .key_strobe (key_strobe),
    .key_code   (key_code),
    .prn_ready  (prn_ready),
    .prn_data   (prn_data),
    .prn_pulse  (prn_pulse),
    .kbd_full   (kbd_full),
    .prn_idle   (prn_idle)
);

// File: tb/kp_io_ports_test.sv
module kp_io_ports_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  io_addr = '0;
    logic        io_rd = 1'b0;
    logic        io_wr = 1'b0;
    logic [15:0] io_wdata = '0;
    logic [15:0] io_rdata;
    logic        key_strobe = 1'b0;
    logic [7:0]  key_code = '0;
    logic        prn_ready = 1'b0;
    logic [7:0]  prn_data;
    logic        prn_pulse;

    always #10 clk = ~clk;

    kp_io_ports uut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd),
        .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .key_strobe(key_strobe), .key_code(key_code), .prn_ready(prn_ready),
        .prn_data(prn_data), .prn_pulse(prn_pulse)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // reference state
    bit       m_kfull;
    bit [7:0] m_kcode;
    bit       m_pidle;
    bit [7:0] m_pbyte;
    bit       m_ppulse;

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(string req, bit rd, bit wr, int addr, int wd,
                       bit ks, int kc, bit pr);
        logic [15:0] exp_rd;
        io_rd = rd; io_wr = wr; io_addr = 8'(addr); io_wdata = 16'(wd);
        key_strobe = ks; key_code = 8'(kc); prn_ready = pr;
        #2;
        exp_rd = 16'h0000;
        if (rd) begin
            if (addr == 0)      exp_rd = {15'b0, m_kfull};
            else if (addr == 1) exp_rd = {8'b0, m_kcode};
            else if (addr == 2) exp_rd = {15'b0, m_pidle};
        end
        check({req, " rdata"}, io_rdata, exp_rd);
        check({req, " prn_data"}, {8'b0, prn_data}, {8'b0, m_pbyte});
        check({req, " prn_pulse"}, {15'b0, prn_pulse}, {15'b0, m_ppulse});
        @(posedge clk);
        m_ppulse = wr && addr == 3;
        if (m_ppulse) m_pbyte = 8'(wd);
        if (ks) begin
            m_kfull = 1; m_kcode = 8'(kc);
        end else if (rd && addr == 1) m_kfull = 0;
        if (pr) m_pidle = 1;
        else if (wr && addr == 3) m_pidle = 0;
        @(negedge clk);
    endtask

    task automatic idle(string req);
        cyc(req, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        m_kfull = 0; m_kcode = 0; m_pidle = 1; m_pbyte = 0; m_ppulse = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        cyc("R1 kstat", 1, 0, 0, 0, 0, 0, 0);
        cyc("R1 pstat", 1, 0, 2, 0, 0, 0, 0);
        cyc("R1 kdata", 1, 0, 1, 0, 0, 0, 0);
        // R10 bus idle
        idle("R10");
        // R3 key latches, R2/R4 port map
        cyc("R3 strobe", 0, 0, 0, 0, 1, 'hA5, 0);
        cyc("R4 kstat set", 1, 0, 0, 0, 0, 0, 0);
        cyc("R5 kstat reread", 1, 0, 0, 0, 0, 0, 0);
        cyc("R2 kdata", 1, 0, 1, 0, 0, 0, 0);
        cyc("R5 cleared", 1, 0, 0, 0, 0, 0, 0);
        // R6 strobe with data read
        cyc("R3 second key", 0, 0, 0, 0, 1, 'h3C, 0);
        cyc("R6 collide", 1, 0, 1, 0, 1, 'h7E, 0);
        cyc("R6 status kept", 1, 0, 0, 0, 0, 0, 0);
        cyc("R6 new code", 1, 0, 1, 0, 0, 0, 0);
        // R7 printer write
        cyc("R7 write", 0, 1, 3, 'h1234, 0, 0, 0);
        cyc("R7 pulse busy", 1, 0, 2, 0, 0, 0, 0);
        cyc("R7 pulse ends", 1, 0, 2, 0, 0, 0, 0);
        // R8 ready
        cyc("R8 ready", 0, 0, 0, 0, 0, 0, 1);
        cyc("R8 set", 1, 0, 2, 0, 0, 0, 0);
        cyc("R8 collide", 0, 1, 3, 'h00C3, 0, 0, 1);
        cyc("R8 ready wins", 1, 0, 2, 0, 0, 0, 0);
        // R9 wrong writes
        cyc("R7 busy again", 0, 1, 3, 'h0055, 0, 0, 0);
        cyc("R9 wr kstat", 0, 1, 0, 'hFFFF, 0, 0, 0);
        cyc("R9 wr kdata", 0, 1, 1, 'hFF11, 0, 0, 0);
        cyc("R9 wr pstat", 0, 1, 2, 'hFF22, 0, 0, 0);
        cyc("R9 wr unmapped", 0, 1, 9, 'hFF33, 0, 0, 0);
        cyc("R9 pstat kept", 1, 0, 2, 0, 0, 0, 0);
        cyc("R9 kdata kept", 1, 0, 1, 0, 0, 0, 0);
        cyc("R9 rd unmapped", 1, 0, 200, 0, 0, 0, 0);
        // R10 no clear without io_rd
        cyc("R10 key", 0, 0, 1, 0, 1, 'h42, 0);
        cyc("R10 addr1 no rd", 0, 0, 1, 0, 0, 0, 0);
        cyc("R10 still set", 1, 0, 0, 0, 0, 0, 0);
        // random mix, back-to-back printer writes included
        for (int i = 0; i < 400; i++) begin
            bit r = 1'($urandom_range(0, 1));
            cyc("R3 R5 R7 R8 random", r, !r && ($urandom_range(0, 2) != 0),
                int'($urandom_range(0, 4)), int'($urandom_range(0, 65535)),
                ($urandom_range(0, 3) == 0), int'($urandom_range(0, 255)),
                ($urandom_range(0, 3) == 0));
        end
        idle("R7 final");
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule